// File: doc/BRIEF.md
# SMRAM Window Access Decoder

This block sits beside the host address path and decides, for every processor access, whether it lands in system-management RAM. If it does, the block works out the physical DRAM address the access must use and where the access goes. Three 128 KB address windows are recognised. The first is the primary window at 000A0000h–000BFFFFh. The other two are high aliases at 0E0A0000h–0E0BFFFFh and 4E0A0000h–4E0BFFFFh. All three are folded onto the same physical range. An access that matches none of them passes through untouched and is sent to the PCI side.

Whether a matching access actually hits depends on the processor mode and on an 8-bit control byte. While the SMM-active input is high, the windows are always open. Outside SMM, they open only if the control byte's open bit (bit 0) is set. A second control bit (bit 5) turns on a split mode. In split mode, a hitting data access goes to PCI and a hitting code fetch goes to DRAM.

The decode path is purely combinational from the address, mode, cycle-type and the stored control byte. The control byte is the only state. It is loaded on a rising clock edge when its write strobe is high. The lookup has no flow control: every access presented is answered in the same cycle.

Top module: `smram_decoder`

## Requirements
- R1: An address from 000A0000h to 000BFFFFh inclusive matches the primary window. 0009FFFFh and 000C0000h do not match. A hitting access in this window leaves `smr_addr` equal to `acc_addr`.
- R2: An address from 0E0A0000h to 0E0BFFFFh inclusive matches. When it hits, `smr_addr` = 000A0000h + (`acc_addr` − 0E0A0000h). 0E09FFFFh and 0E0C0000h do not match.
- R3: An address from 4E0A0000h to 4E0BFFFFh inclusive matches. When it hits, `smr_addr` = 000A0000h + (`acc_addr` − 4E0A0000h). 4E09FFFFh and 4E0C0000h do not match. Nearby high patterns such as 1E0A0000h and 8E0A0000h do not match.
- R4: With `acc_smm` = 1, every matching address gives `smr_hit` = 1, whatever the value of control bit 0.
- R5: With `acc_smm` = 0, a matching address gives `smr_hit` = 1 exactly when control bit 0 is 1.
- R6: On a hit, `smr_to_pci` = 1 (PCI) when control bit 5 is 1 and `acc_code` = 0 (data cycle). Otherwise `smr_to_pci` = 0 (DRAM). `acc_code` = 1 marks a code fetch.
- R7: When `smr_hit` = 0, `smr_addr` equals `acc_addr` and `smr_to_pci` = 1.
- R8: While `rst_n` is low, and after reset until the first write, the control byte is 80h. As a result, outside SMM no window hits, and a hit in SMM is routed to DRAM for both cycle types.
- R9: The control byte takes `ctl_wdata` on a rising `clk` edge with `ctl_we` = 1 and holds otherwise. Bits 7–6 and 4–1 change neither hit, address nor route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control byte |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write value |
| acc_addr | input | 32 | Processor access address |
| acc_smm | input | 1 | 1 while the processor is in SMM |
| acc_code | input | 1 | 1 for a code fetch, 0 for a data cycle |
| smr_hit | output | 1 | Access falls in an open SMRAM window |
| smr_addr | output | 32 | Translated address (pass-through on a miss) |
| smr_to_pci | output | 1 | Route select: 1 = PCI, 0 = DRAM |

## Verification
The hardest case to reach is a split-mode hit outside SMM at the very top byte of a high alias. That case needs three things at once: a control byte with both bit 0 and bit 5 set, SMM low, and an address one below the alias end. A single wrong translation or route there differs from the neighbouring cases in only one output bit. The stimulus walks a list of control bytes, including one with every irrelevant bit set. After each write, it sweeps the edge addresses of every window across all four combinations of SMM and cycle type. Each result is compared against a behavioural model of the same rules.

// File: rtl/smram_pkg.sv
package smram_pkg;

  localparam int unsigned WIN_COUNT = 3;

  // Window 0 is the primary range every alias folds onto.
  localparam logic [31:0] WIN_BASE [WIN_COUNT] = '{
    32'h000A_0000,
    32'h0E0A_0000,
    32'h4E0A_0000
  };

  typedef enum logic {
    ROUTE_DRAM = 1'b0,
    ROUTE_PCI  = 1'b1
  } route_e;

endpackage

// File: rtl/smram_ctl_reg.sv
module smram_ctl_reg #(
  parameter int unsigned   CTL_W   = 8,
  parameter logic [CTL_W-1:0] RST_VAL = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (we) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/smram_win_match.sv
module smram_win_match #(
  parameter int unsigned  ADDR_W    = 32,
  parameter int unsigned  SPAN_LOG2 = 17,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-SPAN_LOG2-1:0] page,
  output logic                        match
);

  localparam logic [ADDR_W-SPAN_LOG2-1:0] BASE_PAGE = BASE[ADDR_W-1:SPAN_LOG2];

  always_comb begin
    match = (page == BASE_PAGE);
  end

endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
(
  input  logic   hit,
  input  logic   code,
  input  logic   split_en,
  output route_e route
);

  always_comb begin
    if (!hit) begin
      route = ROUTE_PCI;
    end else if (split_en && !code) begin
      route = ROUTE_PCI;
    end else begin
      route = ROUTE_DRAM;
    end
  end

endmodule

// File: rtl/smram_decoder.sv
module smram_decoder
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SPAN_LOG2 = 17,
  parameter int unsigned CTL_W     = 8,
  parameter int unsigned OPEN_BIT  = 0,
  parameter int unsigned SPLIT_BIT = 5,
  parameter logic [CTL_W-1:0] CTL_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_code,
  output logic              smr_hit,
  output logic [ADDR_W-1:0] smr_addr,
  output logic              smr_to_pci
);

  localparam int unsigned PAGE_W = ADDR_W - SPAN_LOG2;
  localparam logic [CTL_W-1:0] USED_MASK =
    CTL_W'((1 << OPEN_BIT) | (1 << SPLIT_BIT));
  localparam logic [PAGE_W-1:0] HOME_PAGE =
    WIN_BASE[0][ADDR_W-1:SPAN_LOG2];

  logic [CTL_W-1:0]     ctl_q;
  logic [WIN_COUNT-1:0] win_hit;
  logic                 any_win;
  logic                 win_open;
  logic                 ctl_unused;
  route_e               route;

  smram_ctl_reg #(
    .CTL_W  (CTL_W),
    .RST_VAL(CTL_RST)
  ) u_ctl (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ctl_we),
    .wdata(ctl_wdata),
    .q    (ctl_q)
  );

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
    smram_win_match #(
      .ADDR_W   (ADDR_W),
      .SPAN_LOG2(SPAN_LOG2),
      .BASE     (WIN_BASE[w][ADDR_W-1:0])
    ) u_match (
      .page (acc_addr[ADDR_W-1:SPAN_LOG2]),
      .match(win_hit[w])
    );
  end

  always_comb begin
    any_win  = |win_hit;
    win_open = acc_smm | ctl_q[OPEN_BIT];
    smr_hit  = any_win & win_open;
    if (smr_hit) begin
      smr_addr = {HOME_PAGE, acc_addr[SPAN_LOG2-1:0]};
    end else begin
      smr_addr = acc_addr;
    end
  end

  smram_route u_route (
    .hit     (smr_hit),
    .code    (acc_code),
    .split_en(ctl_q[SPLIT_BIT]),
    .route   (route)
  );

  assign smr_to_pci = (route == ROUTE_PCI);
  assign ctl_unused = ^(ctl_q & ~USED_MASK);

endmodule

// File: rtl/smram_decoder_chk.sv
module smram_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [7:0]  ctl_q,
  input logic [31:0] acc_addr,
  input logic        acc_smm,
  input logic        acc_code,
  input logic        smr_hit,
  input logic [31:0] smr_addr,
  input logic        smr_to_pci
);

  logic in_home;
  assign in_home = (acc_addr >= 32'h000A_0000) && (acc_addr <= 32'h000B_FFFF);

  // R1
  home_hit_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smr_hit && in_home) |-> (smr_addr == acc_addr));

  // R2
  hit_lands_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smr_hit |-> ((smr_addr >= 32'h000A_0000) && (smr_addr <= 32'h000B_FFFF)
                 && (smr_addr[16:0] == acc_addr[16:0])));

  // R4
  smm_always_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_smm && in_home) |-> smr_hit);

  // R5
  outside_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smr_hit && !acc_smm) |-> ctl_q[0]);

  // R6
  code_goes_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smr_hit && acc_code) |-> !smr_to_pci);

  // R6
  no_split_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smr_hit && !ctl_q[5]) |-> !smr_to_pci);

  // R7
  miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smr_hit |-> (smr_to_pci && (smr_addr == acc_addr)));

  // R9
  ctl_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));

endmodule

bind smram_decoder smram_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_q     (ctl_q),
  .acc_addr  (acc_addr),
  .acc_smm   (acc_smm),
  .acc_code  (acc_code),
  .smr_hit   (smr_hit),
  .smr_addr  (smr_addr),
  .smr_to_pci(smr_to_pci)
);

// File: tb/tb_smram_decoder.sv
`timescale 1ns/1ps
module tb_smram_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_smm = 1'b0;
  logic        acc_code = 1'b0;
  logic        smr_hit;
  logic [31:0] smr_addr;
  logic        smr_to_pci;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [7:0] model_ctl = 8'h80;

  always #2.5 clk = ~clk;

  smram_decoder dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_code(acc_code),
    .smr_hit(smr_hit), .smr_addr(smr_addr), .smr_to_pci(smr_to_pci)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit in_range(logic [31:0] a, logic [31:0] lo);
    return (a >= lo) && (a <= lo + 32'h1_FFFF);
  endfunction

  task automatic probe(input logic [31:0] a, input bit smm, input bit code, input string force_tag);
    bit inwin, en, ehit, epci;
    logic [31:0] eaddr;
    string tag;
    @(posedge clk); #1;
    acc_addr = a; acc_smm = smm; acc_code = code;
    inwin = in_range(a, 32'h000A_0000) || in_range(a, 32'h0E0A_0000) || in_range(a, 32'h4E0A_0000);
    en    = smm || model_ctl[0];
    ehit  = inwin && en;
    eaddr = ehit ? (32'h000A_0000 + (a - (a & 32'hFFFE_0000)) ) : a;
    epci  = !ehit || (model_ctl[5] && !code);
    if (force_tag != "") tag = force_tag;
    else if (!ehit) tag = "R7";
    else if (model_ctl[5]) tag = "R6";
    else if (in_range(a, 32'h0E0A_0000)) tag = "R2";
    else if (in_range(a, 32'h4E0A_0000)) tag = "R3";
    else if (smm) tag = "R4";
    else if (model_ctl[0]) tag = "R5";
    else tag = "R1";
    @(negedge clk);
    checks++;
    if (smr_hit !== ehit || smr_addr !== eaddr || smr_to_pci !== epci) begin
      errors++;
      $display("FAIL %s addr=%h smm=%0b code=%0b ctl=%h actual hit=%0b addr=%h pci=%0b expected hit=%0b addr=%h pci=%0b",
               tag, a, smm, code, model_ctl, smr_hit, smr_addr, smr_to_pci, ehit, eaddr, epci);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(posedge clk); #1;
    ctl_we = 1'b1; ctl_wdata = v;
    @(posedge clk); #1;
    ctl_we = 1'b0;
    model_ctl = v;
  endtask

  logic [31:0] bases [3] = '{32'h000A_0000, 32'h0E0A_0000, 32'h4E0A_0000};
  logic [7:0]  ctls  [6] = '{8'h80, 8'h81, 8'hA0, 8'hA1, 8'hDE, 8'hFF};
  logic [31:0] extras [5] = '{32'h1E0A_0000, 32'h8E0A_0000, 32'h001A_0000, 32'hFFFF_FFFF, 32'h0000_0000};

  initial begin
    // R8: reset state seen while reset is held and right after release
    #1;
    probe(32'h000A_0000, 1'b0, 1'b0, "R8");
    probe(32'h000B_FFFF, 1'b1, 1'b0, "R8");
    @(posedge clk); #1 rst_n = 1'b1;
    probe(32'h000A_1234, 1'b0, 1'b1, "R8");
    probe(32'h0E0A_0000, 1'b0, 1'b0, "R8");
    probe(32'h4E0B_FFFF, 1'b1, 1'b0, "R8");

    // R9: data without the strobe must not load
    @(posedge clk); #1 ctl_wdata = 8'h21; ctl_we = 1'b0;
    probe(32'h000A_0000, 1'b0, 1'b0, "R9");
    probe(32'h000B_0000, 1'b1, 1'b0, "R9");

    foreach (ctls[c]) begin
      write_ctl(ctls[c]);
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 2; k++) begin
          foreach (bases[b]) begin
            probe(bases[b] - 32'h1,        s[0], k[0], "");
            probe(bases[b],                s[0], k[0], "");
            probe(bases[b] + 32'h0_1234,   s[0], k[0], "");
            probe(bases[b] + 32'h1_FFFE,   s[0], k[0], "");
            probe(bases[b] + 32'h1_FFFF,   s[0], k[0], "");
            probe(bases[b] + 32'h2_0000,   s[0], k[0], "");
          end
          foreach (extras[e]) probe(extras[e], s[0], k[0], "");
        end
      end
    end

    // R9: ignored bits with open/split clear behave like reset value
    write_ctl(8'hDE);
    probe(32'h0E0A_0040, 1'b0, 1'b0, "R9");
    probe(32'h0E0A_0040, 1'b1, 1'b0, "R9");

    // R8: a second reset restores the closed state after opening
    write_ctl(8'h21);
    probe(32'h000A_0000, 1'b0, 1'b0, "R5");
    @(posedge clk); #1 rst_n = 1'b0;
    model_ctl = 8'h80;
    probe(32'h000A_0000, 1'b0, 1'b0, "R8");
    @(posedge clk); #1 rst_n = 1'b1;
    probe(32'h000A_0000, 1'b0, 1'b0, "R8");
    probe(32'h000A_0000, 1'b1, 1'b0, "R8");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule